// File: doc/BRIEF.md
# Pulse-to-Level Decoder with Watchdog and Supply Lockout

This block sits on the receiving side of one channel of an isolated link. Edges of the data signal arrive as single-cycle pulses: a "set" pulse for a rising edge and a "clear" pulse for a falling edge. The sender also repeats these pulses at a steady rate while the data is idle. The block rebuilds the logic level from them with a bistable element, which holds its state between pulses. With every supply good, the output follows the decoded level directly, with no inversion.

Two conditions override the rebuilt level and force the output to its safe default, which is low.
- **Lost pulses.** When no pulse has been seen for a programmable number of cycles, the link is taken to be dead and the output is forced low.
- **Supply lockout.** Supply-good flags can force the output low. A parameter mask picks which flags gate this channel. A high-side instance is gated by the input-side flag and its own isolated rail. A low-side instance is gated by the input-side flag and its own rail instead. A rail outside the mask has no effect.

Once forced, the channel stays low until a fresh pulse arrives with every gating supply good. A status output tells whether the default is currently being forced. Timeouts are given in clock cycles.

Top module: `iso_pulse_decoder`

## Requirements
- R1: After reset, `out_level` is 0 and `forced` is 1. They stay so until the first pulse is sampled with every gating supply good.
- R2: A sampled `set_pulse` with `clr_pulse` low and no active lockout makes `out_level` 1 and `forced` 0 from the next cycle. A rise of `out_level` only ever follows a sampled `set_pulse`.
- R3: A sampled `clr_pulse` makes `out_level` 0 from the next cycle, while `forced` stays 0 when there is no lockout.
- R4: When `set_pulse` and `clr_pulse` are sampled in the same cycle, the clear wins and `out_level` is 0 in the next cycle.
- R5: Between pulses the output holds its last level, as long as fewer than `WD_CYCLES` consecutive edges have passed with no pulse and no lockout is active.
- R6: Once `WD_CYCLES` consecutive clock edges have sampled no pulse, `out_level` is 0 and `forced` is 1 in the cycle that follows.
- R7: Any sampled pulse restarts the watchdog. After a timeout, the next valid pulse restores the decoded level in the following cycle.
- R8: Bit i of `supply_ok` gates the channel when bit i of `SUP_MASK` is 1. While any gating bit is 0, `out_level` is 0 and `forced` is 1 in that same cycle, with no clock edge needed.
- R9: A `supply_ok` bit whose `SUP_MASK` bit is 0 has no effect on the outputs. The rail of the other channel therefore never disturbs this one.
- R10: Pulses sampled during a lockout are ignored. After the lockout clears, the output stays low with `forced` at 1 until a pulse is sampled with all gating supplies good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_pulse | input | 1 | Single-cycle pulse for a rising data edge or a high refresh |
| clr_pulse | input | 1 | Single-cycle pulse for a falling data edge or a low refresh |
| supply_ok | input | NSUP | Supply-good flags; bit i gates the channel when SUP_MASK[i] is 1 |
| out_level | output | 1 | Rebuilt data level after the watchdog and lockout gating |
| forced | output | 1 | 1 while the channel is held at its low default |

## Verification
The bench aims at three points:
- **Watchdog boundary.** It compares a gap of `WD_CYCLES-1` idle edges, which must keep the level, with a gap of `WD_CYCLES` idle edges, which must force it low. An off-by-one counter would time out one cycle early or one cycle late.
- **Clear against set.** It drives both pulses in the same cycle. A design with the wrong priority would drive the output high.
- **Leaving a lockout.** It sends pulses during a lockout and then lets the supply recover with no new pulse. A design that kept latching during the lockout, or that released on supply recovery alone, would show a stale high level.

Both a high-side and a low-side instance run together, so that a mask fault showing up as cross-channel gating is seen at the ports. A long seeded random phase then mixes pulse rates and supply dropouts against a model computed in the bench.

// File: rtl/iso_pulse_decoder.sv
module iso_pulse_decoder #(
  parameter int WD_CYCLES = 500,
  parameter int NSUP = 3,
  parameter logic [NSUP-1:0] SUP_MASK = {NSUP{1'b1}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_pulse,
  input  logic            clr_pulse,
  input  logic [NSUP-1:0] supply_ok,
  output logic            out_level,
  output logic            forced
);

  localparam int CW = $clog2(WD_CYCLES + 1);
  localparam logic [CW-1:0] WD_LIM = CW'(WD_CYCLES);

  logic [CW-1:0] gap_cnt;
  logic          lvl_q;
  logic          hold_q;

  wire lockout   = |(~supply_ok & SUP_MASK);
  wire any_pulse = set_pulse | clr_pulse;
  wire expired   = (gap_cnt == WD_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= WD_LIM;
    end else if (any_pulse) begin
      gap_cnt <= '0;
    end else if (!expired) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      hold_q <= 1'b1;
    end else if (lockout) begin
      lvl_q  <= 1'b0;
      hold_q <= 1'b1;
    end else if (any_pulse) begin
      lvl_q  <= set_pulse & ~clr_pulse;
      hold_q <= 1'b0;
    end else if (expired) begin
      lvl_q  <= 1'b0;
      hold_q <= 1'b1;
    end
  end

  assign forced    = lockout | expired | hold_q;
  assign out_level = lvl_q & ~forced;

  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse && !clr_pulse && !lockout) |=> (out_level || lockout)); // R2
  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_level) |-> $past(set_pulse)); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !out_level); // R4
  AST_WD_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(any_pulse) && $past(gap_cnt) == WD_LIM - 1'b1) |-> (!out_level && forced)); // R6
  AST_PULSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |=> !expired); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= WD_LIM); // R6
  AST_RECOVERY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lockout) && !lockout) |-> forced); // R10

endmodule

// File: tb/iso_pulse_decoder_bench.sv
module iso_pulse_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD = 12;
  localparam logic [2:0] MASK_HI = 3'b011;
  localparam logic [2:0] MASK_LO = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] set_i = '0, clr_i = '0;
  logic [2:0] sup = 3'b111;
  logic [1:0] out_o, frc_o;
  int checks = 0, errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_pulse_decoder #(.WD_CYCLES(WD), .NSUP(3), .SUP_MASK(MASK_HI)) u_iso_pulse_decoder (
    .clk(clk), .rst_n(rst_n), .set_pulse(set_i[0]), .clr_pulse(clr_i[0]),
    .supply_ok(sup), .out_level(out_o[0]), .forced(frc_o[0]));
  iso_pulse_decoder #(.WD_CYCLES(WD), .NSUP(3), .SUP_MASK(MASK_LO)) u_iso_pulse_decoder_lo (
    .clk(clk), .rst_n(rst_n), .set_pulse(set_i[1]), .clr_pulse(clr_i[1]),
    .supply_ok(sup), .out_level(out_o[1]), .forced(frc_o[1]));

  int  m_gap [2];
  logic m_valid [2];
  logic m_lvl [2];

  function automatic logic locked(int c);
    return |(~sup & (c == 0 ? MASK_HI : MASK_LO));
  endfunction
  function automatic logic exp_forced(int c);
    return locked(c) || m_gap[c] >= WD || !m_valid[c];
  endfunction
  function automatic logic exp_out(int c);
    return !exp_forced(c) && m_lvl[c];
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        m_gap[c] <= WD; m_valid[c] <= 1'b0; m_lvl[c] <= 1'b0;
      end else begin
        if (set_i[c] || clr_i[c]) m_gap[c] <= 0;
        else if (m_gap[c] < WD) m_gap[c] <= m_gap[c] + 1;
        if (locked(c)) m_valid[c] <= 1'b0;
        else if (set_i[c] || clr_i[c]) begin
          m_valid[c] <= 1'b1; m_lvl[c] <= set_i[c] && !clr_i[c];
        end
      end
    end
  end

  task automatic want(int c, string tag, logic eo, logic ef);
    checks++;
    if (out_o[c] !== eo || frc_o[c] !== ef) begin
      errs++;
      $display("FAIL %s ch%0d: out=%b forced=%b expected out=%b forced=%b",
               tag, c, out_o[c], frc_o[c], eo, ef);
    end
  endtask

  task automatic auto_check();
    for (int c = 0; c < 2; c++) begin
      string tag;
      if (locked(c)) tag = "R8";
      else if (m_gap[c] >= WD) tag = "R6";
      else if (!m_valid[c]) tag = "R10";
      else tag = "R5";
      want(c, tag, exp_out(c), exp_forced(c));
    end
  endtask

  task automatic cyc(logic [1:0] s, logic [1:0] r, logic [2:0] sp);
    set_i = s; clr_i = r; sup = sp;
    @(posedge clk); #1;
    auto_check();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int rate;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    want(0, "R1", 1'b0, 1'b1); want(1, "R1", 1'b0, 1'b1);
    cyc(2'b00, 2'b00, 3'b111);
    want(0, "R1", 1'b0, 1'b1);
    cyc(2'b01, 2'b00, 3'b111); want(0, "R2", 1'b1, 1'b0);
    repeat (5) cyc(2'b00, 2'b00, 3'b111);
    want(0, "R5", 1'b1, 1'b0);
    cyc(2'b00, 2'b01, 3'b111); want(0, "R3", 1'b0, 1'b0);
    cyc(2'b01, 2'b00, 3'b111);
    cyc(2'b01, 2'b01, 3'b111); want(0, "R4", 1'b0, 1'b0);
    cyc(2'b11, 2'b00, 3'b111); want(0, "R2", 1'b1, 1'b0); want(1, "R2", 1'b1, 1'b0);
    cyc(2'b00, 2'b00, 3'b101); want(0, "R8", 1'b0, 1'b1); want(1, "R9", 1'b1, 1'b0);
    cyc(2'b01, 2'b00, 3'b101); want(0, "R10", 1'b0, 1'b1);
    cyc(2'b00, 2'b00, 3'b111); want(0, "R10", 1'b0, 1'b1);
    cyc(2'b11, 2'b00, 3'b011); want(0, "R9", 1'b1, 1'b0); want(1, "R8", 1'b0, 1'b1);
    repeat (WD - 1) cyc(2'b00, 2'b00, 3'b111);
    want(0, "R5", 1'b1, 1'b0);
    cyc(2'b00, 2'b00, 3'b111); want(0, "R6", 1'b0, 1'b1);
    cyc(2'b01, 2'b00, 3'b111); want(0, "R7", 1'b1, 1'b0);
    cyc(2'b10, 2'b00, 3'b111); want(1, "R10", 1'b1, 1'b0);

    void'($urandom(32'd20240611));
    for (int blk = 0; blk < 20; blk++) begin
      rate = (blk % 3 == 0) ? 3 : (blk % 3 == 1) ? 9 : 20;
      for (int i = 0; i < 150; i++) begin
        logic [1:0] s, r;
        logic [2:0] sp;
        sp = sup;
        if (sp != 3'b111 && $urandom_range(0, 7) == 0) sp = 3'b111;
        else if ($urandom_range(0, 40) == 0) sp[$urandom_range(0, 2)] = 1'b0;
        for (int c = 0; c < 2; c++) begin
          s[c] = ($urandom_range(0, rate) == 0);
          r[c] = ($urandom_range(0, rate) == 0);
        end
        cyc(s, r, sp);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule